// File: doc/BRIEF.md
# Dual-Bank Programmable Clock Divider

This block sits after a fast synthesized source clock and produces two independent banks of divided clocks, A and B. Each bank takes its own 6-bit configuration code and divides the source by twice that code, so the two banks can run at unrelated output frequencies. One code is reserved and gives the odd ratio 15 instead of 14. That ratio uses a near-50% duty scheme built from one register on the rising source edge and one on the falling edge. Each bank drives four copies of its clock from one internal signal, so the copies stay aligned.

On the reference side, the block chooses one of three reference inputs to pass on. That reference goes to a buffered copy output that is always on and to a second copy output that has its own enable. In bypass mode the chosen reference drives both banks in place of the divided clocks. An active-low master reset forces every bank output low and clears the counters. A new configuration code is taken up only at the next rising edge of that bank's output, so a change in ratio never produces a short pulse.

Top module: `clkdiv_dual`

## Requirements
- R1: For codes 4 to 63 other than 7, the bank divides by N = 2 x code with exactly N/2 source cycles high and N/2 low. The code port index 0 is the most significant bit, so code 6'b100000 (index 0 set) is 32 and gives N = 64.
- R2: Code 7 gives ratio 15. The output is high for 7.5 source cycles and low for 7.5 source cycles (15 half-cycles each).
- R3: Codes 0 to 3 clamp to ratio 8 and drive that bank's error flag high. For every other code the error flag is low.
- R4: Banks A and B divide independently by their own codes. The four copies of a bank are equal at all times.
- R5: A code change takes effect only at the next rising edge of that bank's output. The period already in progress completes with the old ratio.
- R6: While rst_ni is low, all bank outputs are low. After release, each bank's first output rise comes N/2 source cycles after release, where N is the ratio selected by the code applied at release.
- R7: With bypass_i high, every bank copy equals the selected reference. Reset still forces the bank outputs low in bypass.
- R8: Reference selection: xtal_pick_i = 1 selects xtal_i. Otherwise ref_pick_i = 0 selects ref_a_i and ref_pick_i = 1 selects ref_b_i.
- R9: ref_copy_o[0] always follows the selected reference, including during reset. ref_copy_o[1] follows it when ref2_en_i is high and is held low when ref2_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| ref_a_i | input | 1 | First external reference |
| ref_b_i | input | 1 | Second external reference |
| xtal_i | input | 1 | Crystal-path reference |
| ref_pick_i | input | 1 | 0 selects ref_a_i, 1 selects ref_b_i |
| xtal_pick_i | input | 1 | 1 selects xtal_i over the external references |
| bypass_i | input | 1 | 1 drives the banks from the selected reference |
| ref2_en_i | input | 1 | Enable for ref_copy_o[1] |
| cfg_a_i | input | 6 | Bank A code, index 0 is the MSB |
| cfg_b_i | input | 6 | Bank B code, index 0 is the MSB |
| bank_a_o | output | 4 | Bank A clock copies |
| bank_b_o | output | 4 | Bank B clock copies |
| ref_copy_o | output | 2 | Buffered reference copies |
| cfg_err_a_o | output | 1 | Bank A code is below the minimum |
| cfg_err_b_o | output | 1 | Bank B code is below the minimum |

## Verification
The hardest case to produce from the ports is a code change that lands in the middle of a period. The stimulus has to show that the period in progress still completes with the old ratio, and that the old ratio is not cut short. To reach it, the stimulus first locks onto an observed rising edge of the even-ratio output. It changes the code in the half-cycle just after that edge and then measures the high and low times of that period and of the next one, at half-cycle resolution. Odd-ratio timing is checked the same way: the bench samples every half-cycle, so a 7.5-cycle high time is seen as 15 samples. Random codes, including the clamped ones, are applied to both banks with a fixed seed. Directed cases cover the first rise after reset and the full table of reference selections in bypass.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CFG_W = 6;
  localparam int unsigned LEN_W = CFG_W;  // phase length in source cycles

  typedef logic [CFG_W-1:0] code_t;

  typedef struct packed {
    logic [LEN_W-1:0] hi_len;
    logic [LEN_W-1:0] lo_len;
    logic             odd;
    logic             err;
  } phase_t;

  // odd ratio: high phase one cycle longer on the posedge grid, trimmed by the negedge copy
  function automatic phase_t decode_code(code_t c, int unsigned min_code,
                                         int unsigned odd_code);
    phase_t      p;
    int unsigned cv;
    cv = 32'(c);
    p  = '0;
    if (cv == odd_code) begin
      p.hi_len = LEN_W'(odd_code + 1);
      p.lo_len = LEN_W'(odd_code);
      p.odd    = 1'b1;
    end else if (cv < min_code) begin
      p.hi_len = LEN_W'(min_code);
      p.lo_len = LEN_W'(min_code);
      p.err    = 1'b1;
    end else begin
      p.hi_len = c;
      p.lo_len = c;
    end
    return p;
  endfunction
endpackage

// File: rtl/clkdiv_ref_sel.sv
module clkdiv_ref_sel (
  input  logic       ref_a_i,
  input  logic       ref_b_i,
  input  logic       xtal_i,
  input  logic       ref_pick_i,
  input  logic       xtal_pick_i,
  input  logic       ref2_en_i,
  output logic       ref_sel_o,
  output logic [1:0] ref_copy_o
);
  logic ext_ref;

  assign ext_ref       = ref_pick_i ? ref_b_i : ref_a_i;
  assign ref_sel_o     = xtal_pick_i ? xtal_i : ext_ref;
  assign ref_copy_o[0] = ref_sel_o;
  assign ref_copy_o[1] = ref2_en_i & ref_sel_o;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned MIN_CODE = 4,
  parameter int unsigned ODD_CODE = 7
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t cfg_i,
  output logic  div_o,
  output logic  err_o
);
  localparam phase_t RST_PHASE = decode_code('1, MIN_CODE, ODD_CODE);

  phase_t           dec;
  phase_t           act_q;
  logic             init_q;
  logic [LEN_W-1:0] rem_q;
  logic             out_p_q;
  logic             out_n_q;

  assign dec   = decode_code(cfg_i, MIN_CODE, ODD_CODE);
  assign err_o = dec.err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      act_q   <= RST_PHASE;
      rem_q   <= '0;
      out_p_q <= 1'b0;
    end else if (init_q) begin
      init_q <= 1'b0;
      act_q  <= dec;
      rem_q  <= dec.lo_len - LEN_W'(1);
    end else if (rem_q == LEN_W'(1)) begin
      out_p_q <= ~out_p_q;
      if (!out_p_q) begin
        // rising edge: the only point where a new code is taken up
        act_q <= dec;
        rem_q <= dec.hi_len;
      end else begin
        rem_q <= act_q.lo_len;
      end
    end else begin
      rem_q <= rem_q - LEN_W'(1);
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_n_q <= 1'b0;
    else         out_n_q <= out_p_q;
  end

  assign div_o = act_q.odd ? (out_p_q & out_n_q) : out_p_q;

  // R5: active ratio moves only at an output rise or at start-up
  a_r5_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> ($rose(out_p_q) || $past(init_q)));

  // R1: the phase register toggles only when the phase counter expires
  a_r1_toggle_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_p_q) |-> ($past(rem_q) == LEN_W'(1)));

  // R1: remaining count never exceeds the longest active phase
  a_r1_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= act_q.hi_len);

  // R6: no output activity before the start-up load
  a_r6_init_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> !div_o);
endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
  parameter int unsigned COPIES = 4
) (
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              ref_i,
  input  logic              div_i,
  output logic [COPIES-1:0] q_o
);
  logic drive;

  assign drive = rst_ni & (bypass_i ? ref_i : div_i);

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    assign q_o[g] = drive;
  end
endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
  import clkdiv_pkg::*;
#(
  parameter int unsigned COPIES   = 4,
  parameter int unsigned MIN_CODE = 4,
  parameter int unsigned ODD_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_a_i,
  input  logic              ref_b_i,
  input  logic              xtal_i,
  input  logic              ref_pick_i,
  input  logic              xtal_pick_i,
  input  logic              bypass_i,
  input  logic              ref2_en_i,
  input  logic [0:CFG_W-1]  cfg_a_i,
  input  logic [0:CFG_W-1]  cfg_b_i,
  output logic [COPIES-1:0] bank_a_o,
  output logic [COPIES-1:0] bank_b_o,
  output logic [1:0]        ref_copy_o,
  output logic              cfg_err_a_o,
  output logic              cfg_err_b_o
);
  code_t code_a;
  code_t code_b;
  logic  ref_sel;
  logic  div_a;
  logic  div_b;

  // index 0 of the port is the MSB, so a plain packed copy keeps the value
  assign code_a = cfg_a_i;
  assign code_b = cfg_b_i;

  clkdiv_ref_sel u_ref_sel (
    .ref_a_i    (ref_a_i),
    .ref_b_i    (ref_b_i),
    .xtal_i     (xtal_i),
    .ref_pick_i (ref_pick_i),
    .xtal_pick_i(xtal_pick_i),
    .ref2_en_i  (ref2_en_i),
    .ref_sel_o  (ref_sel),
    .ref_copy_o (ref_copy_o)
  );

  clkdiv_bank #(.MIN_CODE(MIN_CODE), .ODD_CODE(ODD_CODE)) u_bank_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (code_a),
    .div_o (div_a),
    .err_o (cfg_err_a_o)
  );

  clkdiv_bank #(.MIN_CODE(MIN_CODE), .ODD_CODE(ODD_CODE)) u_bank_b (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (code_b),
    .div_o (div_b),
    .err_o (cfg_err_b_o)
  );

  clkdiv_fanout #(.COPIES(COPIES)) u_fan_a (
    .rst_ni  (rst_ni),
    .bypass_i(bypass_i),
    .ref_i   (ref_sel),
    .div_i   (div_a),
    .q_o     (bank_a_o)
  );

  clkdiv_fanout #(.COPIES(COPIES)) u_fan_b (
    .rst_ni  (rst_ni),
    .bypass_i(bypass_i),
    .ref_i   (ref_sel),
    .div_i   (div_b),
    .q_o     (bank_b_o)
  );

  // R7: reset wins over both the divided path and bypass
  always_comb begin
    if (!rst_ni) begin
      a_r7_reset_low: assert (bank_a_o == '0 && bank_b_o == '0);
    end
  end

  // R9: second reference copy is off when not enabled
  always_comb begin
    if (ref2_en_i == 1'b0) begin
      a_r9_ref2_off: assert (ref_copy_o[1] == 1'b0);
    end
  end
endmodule

// File: tb/clkdiv_dual_tb.sv
`timescale 1ns/1ps
module clkdiv_dual_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_a = 1'b0, ref_b = 1'b0, xtal = 1'b0;
  logic       ref_pick = 1'b0, xtal_pick = 1'b0, bypass = 1'b0, ref2_en = 1'b0;
  logic [0:5] cfg_a = 6'h3f, cfg_b = 6'h3f;
  logic [3:0] bank_a, bank_b;
  logic [1:0] ref_copy;
  logic       err_a, err_b;

  int total = 0;
  int bad = 0;
  int copy_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clkdiv_dual u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_a_i(ref_a), .ref_b_i(ref_b), .xtal_i(xtal),
    .ref_pick_i(ref_pick), .xtal_pick_i(xtal_pick), .bypass_i(bypass), .ref2_en_i(ref2_en),
    .cfg_a_i(cfg_a), .cfg_b_i(cfg_b), .bank_a_o(bank_a), .bank_b_o(bank_b),
    .ref_copy_o(ref_copy), .cfg_err_a_o(err_a), .cfg_err_b_o(err_b)
  );

  function automatic int exp_n(int c);
    if (c == 7) return 15;
    if (c < 4) return 8;
    return 2 * c;
  endfunction

  function automatic int exp_err(int c);
    return (c < 4) ? 1 : 0;
  endfunction

  function automatic logic sig(bit b);
    return b ? bank_b[0] : bank_a[0];
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one sample per source half-cycle, 2 ns after each edge
  task automatic half();
    @(clk);
    #2;
    if (bank_a != {4{bank_a[0]}}) copy_bad++;
    if (bank_b != {4{bank_b[0]}}) copy_bad++;
  endtask

  task automatic wait_rise(bit b);
    logic v;
    v = sig(b);
    forever begin
      half();
      if (!v && sig(b)) break;
      v = sig(b);
    end
  endtask

  // starts on a high sample, ends on the sample of the next rise
  task automatic count_phase(bit b, output int hi, output int lo);
    hi = 1;
    forever begin half(); if (sig(b)) hi++; else break; end
    lo = 1;
    forever begin half(); if (!sig(b)) lo++; else break; end
  endtask

  task automatic measure(bit b, output int hi, output int lo);
    int dh, dl;
    wait_rise(b);
    count_phase(b, dh, dl);
    count_phase(b, hi, lo);
  endtask

  task automatic check_code(string req, bit b, int c);
    int hi, lo;
    measure(b, hi, lo);
    chk({req, " high half-cycles"}, hi, exp_n(c));
    chk({req, " low half-cycles"}, lo, exp_n(c));
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, fa, fb, n;
    void'($urandom(32'd1234));

    // R6: outputs low under reset, also with bypass and a high reference
    cfg_a = 6'd7;
    cfg_b = 6'd5;
    repeat (4) @(posedge clk);
    #2;
    chk("R6 reset bank_a", int'(bank_a), 0);
    chk("R6 reset bank_b", int'(bank_b), 0);
    ref_a = 1'b1; bypass = 1'b1; ref2_en = 1'b1;
    #1;
    chk("R7 reset beats bypass", int'(bank_a | bank_b), 0);
    chk("R9 copy0 follows ref in reset", int'(ref_copy[0]), 1);
    ref_a = 1'b0; bypass = 1'b0; ref2_en = 1'b0;

    // R6: first rise N/2 cycles after release -> N-1 samples from a negedge release
    @(negedge clk);
    #2;
    rst_ni = 1'b1;
    fa = 0; fb = 0; n = 0;
    while ((fa == 0 || fb == 0) && n < 400) begin
      half();
      n++;
      if (fa == 0 && bank_a[0]) fa = n;
      if (fb == 0 && bank_b[0]) fb = n;
    end
    chk("R6 first rise odd bank_a", fa, exp_n(7) - 1);
    chk("R6 first rise even bank_b", fb, exp_n(5) - 1);

    // R2: odd ratio
    check_code("R2 code7", 1'b0, 7);

    // R1: minimum, maximum, msb position
    cfg_a = 6'd4; check_code("R1 code4", 1'b0, 4);
    cfg_a = 6'b111111; check_code("R1 code63", 1'b0, 63);
    cfg_a = 6'b100000; check_code("R1 msb index0", 1'b0, 32);

    // R3: clamp and error flag
    cfg_a = 6'd0; #1; chk("R3 err code0", int'(err_a), 1);
    check_code("R3 code0 clamp", 1'b0, 0);
    cfg_a = 6'd3; #1; chk("R3 err code3", int'(err_a), 1);
    check_code("R3 code3 clamp", 1'b0, 3);
    cfg_a = 6'd4; #1; chk("R3 err code4", int'(err_a), 0);
    cfg_a = 6'd7; #1; chk("R3 err code7", int'(err_a), 0);

    // R4 / R1 / R3: random codes on both banks
    for (int i = 0; i < 16; i++) begin
      int ca, cb;
      ca = int'($urandom_range(0, 63));
      cb = (i % 4 == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 63));
      cfg_a = 6'(ca);
      cfg_b = 6'(cb);
      #1;
      chk("R3 random err_a", int'(err_a), exp_err(ca));
      chk("R3 random err_b", int'(err_b), exp_err(cb));
      check_code("R4 random bank_a", 1'b0, ca);
      check_code("R4 random bank_b", 1'b1, cb);
    end

    // R5: change right after an observed rise of an even ratio
    cfg_a = 6'd20;
    measure(1'b0, hi, lo);
    wait_rise(1'b0);
    cfg_a = 6'd5;
    count_phase(1'b0, hi, lo);
    chk("R5 old high kept", hi, 40);
    chk("R5 old low kept", lo, 40);
    count_phase(1'b0, hi, lo);
    chk("R5 new high", hi, 10);
    chk("R5 new low", lo, 10);

    // R7 / R8 / R9: bypass and reference selection
    bypass = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 8; p++) begin
        logic e;
        ref_pick  = s[0];
        xtal_pick = s[1];
        {ref_a, ref_b, xtal} = p[2:0];
        ref2_en   = p[0] ^ s[0];
        #1;
        e = xtal_pick ? xtal : (ref_pick ? ref_b : ref_a);
        chk("R7 R8 bypass bank_a", int'(bank_a), e ? 15 : 0);
        chk("R7 R8 bypass bank_b", int'(bank_b), e ? 15 : 0);
        chk("R9 copy0", int'(ref_copy[0]), int'(e));
        chk("R9 copy1 enable", int'(ref_copy[1]), int'(e & ref2_en));
      end
    end
    bypass = 1'b0;
    {ref_a, ref_b, xtal} = 3'b000;

    check_code("R4 after bypass bank_b", 1'b1, int'(cfg_b));
    chk("R4 copies identical", copy_bad, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule